// File: doc/BRIEF.md
# Low-Side Gate Control Register Block

This block sits on a simple register bus and controls the gates of a small set of low-side drivers (two by default). Each channel has a stored gate bit, a driver-enable bit and a route bit. The route bit picks what drives the gate. When it is clear, the gate follows the stored bit. When it is set, the gate follows a live signal routed in from outside the block. A per-channel select input chooses that signal: a timer output-compare line or a PWM line.

Reads of the gate-bit register show the stored bit for channels that are not routed and the live routed level for channels that are. A STOP-entry pulse clears all stored gate bits.

A gate cannot turn on at the moment its driver is enabled. A per-channel settling counter holds the gate off for a parameterised number of clock cycles after each 0-to-1 transition of the enable bit. The gate output is the chosen source ANDed with the channel enable and the settled flag.

Top module: `lsgate_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the stored gate bits, the enable bits and the route bits are all zero, every read returns 0 and `gate_out` is 0.
- R2: The gate-bit register sits at offset 0x0. A write stores `wdata[1:0]` (bit n belongs to channel n). When a channel's route bit is clear, a read of bit n returns the stored bit. Bits 7 to 2 always read 0, and writes to them are ignored.
- R3: The control register sits at offset 0x1. Bits 1:0 are the per-channel driver enables and bits 5:4 are the per-channel route bits (bit 4 belongs to channel 0). All other bits read 0, and writes to them are ignored.
- R4: When a channel's route bit is 1, a read of its bit at offset 0x0 returns the live routed source: `oc_in[n]` when `pwm_sel[n]` is 0 and `pwm_in[n]` when it is 1. The stored bit is left unchanged and reads back again once the route bit is cleared.
- R5: `gate_out[n]` equals the chosen source (the stored bit or the routed source) ANDed with enable n and the settled flag of channel n.
- R6: A write that changes enable n from 0 to 1 holds `gate_out[n]` at 0 for exactly SETTLE_CYC clock cycles after the write edge. Dropping the enable and raising it again restarts the full delay.
- R7: A high `stop_entry` clears every stored gate bit at the next clock edge. This takes priority over a write in the same cycle and leaves the control register unchanged.
- R8: Offsets other than 0x0 and 0x1 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| stop_entry | input | 1 | STOP-mode entry, clears the stored gate bits |
| oc_in | input | 2 | Routed timer output-compare levels, one per channel |
| pwm_in | input | 2 | Routed PWM levels, one per channel |
| pwm_sel | input | 2 | Per channel: 1 picks PWM, 0 picks output-compare |
| gate_out | output | 2 | Gate drive, one per channel |

## Verification
The bench measures the settling window cycle by cycle, on the first enable and again after the enable is dropped and raised. A counter that is off by one, or that does not reload, would let the gate turn on one cycle early or late, or at once on the second enable.

It sweeps all 64 combinations of output-compare, PWM and select levels with both channels routed. A swapped mux, or readback of the stored bit in place of the live source, shows up as wrong read data or wrong gate levels.

It also drives STOP entry in the same cycle as a data write. A design that gives the write priority keeps the gate bits set. Full 256-value sweeps of both registers show any write leaking into unimplemented bits.

// File: rtl/lsgate_pkg.sv
// Package: shared constants of the low-side gate control block.
// Assumes the channel count is at most 4, so every field fits in 8 bits.
package lsgate_pkg;
    localparam int unsigned OFS_GATE  = 0;   // stored gate-bit register
    localparam int unsigned OFS_CTRL  = 1;   // enable and route register
    localparam int unsigned ROUTE_LSB = 4;   // first route bit in the control register
endpackage

// File: rtl/lsgate_regs.sv
// Module: register file of the gate block.
// Holds the stored gate bits, the enables and the route bits, and forms the read data.
// Assumes NCH <= 4 and DW >= ROUTE_LSB + NCH.
module lsgate_regs #(
    parameter int unsigned NCH = 2,
    parameter int unsigned AW  = 4,
    parameter int unsigned DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic           wr_en,
    input  logic [DW-1:0]  wdata,
    input  logic           stop_entry,
    input  logic [NCH-1:0] live_src,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] gate_q,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] route_q
);
    import lsgate_pkg::*;

    localparam logic [AW-1:0] A_GATE = AW'(OFS_GATE);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

    logic hit_gate, hit_ctrl;
    assign hit_gate = (addr == A_GATE);
    assign hit_ctrl = (addr == A_CTRL);

    // Only the implemented bits of wdata are stored; the rest are consumed here.
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata;

    // Stored gate bits: STOP entry clears them and wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  gate_q <= '0;
        else if (stop_entry)         gate_q <= '0;
        else if (wr_en && hit_gate)  gate_q <= wdata[NCH-1:0];
    end

    // Enable and route bits, written at the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
        end else if (wr_en && hit_ctrl) begin
            en_q    <= wdata[NCH-1:0];
            route_q <= wdata[ROUTE_LSB +: NCH];
        end
    end

    // Read mux: a routed channel shows its live source in place of the stored bit.
    always_comb begin
        rdata = '0;
        if (hit_gate) begin
            rdata[NCH-1:0] = (route_q & live_src) | (~route_q & gate_q);
        end else if (hit_ctrl) begin
            rdata[NCH-1:0]         = en_q;
            rdata[ROUTE_LSB +: NCH] = route_q;
        end
    end

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_entry |=> (gate_q == '0)); // R7
    AST_GATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_gate && !stop_entry) |=> (gate_q == $past(wdata[NCH-1:0]))); // R2
    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_gate |-> (rdata[DW-1:NCH] == '0)); // R2
endmodule

// File: rtl/lsgate_settle.sv
// Module: settling timer for one channel.
// Reloads while the enable is low and counts down while it is high; done is set when the count reaches zero.
// Assumes SETTLE_CYC >= 1.
module lsgate_settle #(
    parameter int unsigned SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int unsigned CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt;

    // Reload while disabled, count down to zero while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= CW'(SETTLE_CYC);
        else if (!en)          cnt <= CW'(SETTLE_CYC);
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign done = en && (cnt == '0);

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> !done); // R6
    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(done)) |-> done); // R6
endmodule

// File: rtl/lsgate_chan.sv
// Module: source select and gate qualification for one channel.
// Picks the output-compare or PWM line, then picks that or the stored bit, then qualifies the result.
// Assumes all inputs are synchronous to the block clock.
module lsgate_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_bit,
    input  logic route,
    input  logic en,
    input  logic done,
    input  logic oc,
    input  logic pwm,
    input  logic pwm_sel,
    output logic live_src,
    output logic gate
);
    // Routed source: PWM when selected, output-compare otherwise.
    assign live_src = pwm_sel ? pwm : oc;

    // Gate: chosen source, qualified by the enable and the settled flag.
    assign gate = (route ? live_src : gate_bit) && en && done;

    AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (en && done)); // R5
endmodule

// File: rtl/lsgate_ctrl.sv
// Module: top of the low-side gate control block.
// Connects the register file to one settling timer and one source selector per channel.
// Assumes NCH <= 4 and a single clock domain.
module lsgate_ctrl #(
    parameter int unsigned NCH        = 2,
    parameter int unsigned AW         = 4,
    parameter int unsigned DW         = 8,
    parameter int unsigned SETTLE_CYC = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic           wr_en,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic           stop_entry,
    input  logic [NCH-1:0] oc_in,
    input  logic [NCH-1:0] pwm_in,
    input  logic [NCH-1:0] pwm_sel,
    output logic [NCH-1:0] gate_out
);
    logic [NCH-1:0] gate_q, en_q, route_q, live_src, done;

    lsgate_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .stop_entry(stop_entry), .live_src(live_src), .rdata(rdata),
        .gate_q(gate_q), .en_q(en_q), .route_q(route_q)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        lsgate_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
            .clk(clk), .rst_n(rst_n), .en(en_q[i]), .done(done[i])
        );
        lsgate_chan u_chan (
            .clk(clk), .rst_n(rst_n), .gate_bit(gate_q[i]), .route(route_q[i]),
            .en(en_q[i]), .done(done[i]), .oc(oc_in[i]), .pwm(pwm_in[i]),
            .pwm_sel(pwm_sel[i]), .live_src(live_src[i]), .gate(gate_out[i])
        );
    end

    AST_ROUTED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == AW'(0)) && route_q[0]) |-> (rdata[0] == (pwm_sel[0] ? pwm_in[0] : oc_in[0]))); // R4
endmodule

// File: tb/lsgate_ctrl_tb.sv
module lsgate_ctrl_tb;
    localparam int S = 8;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] addr = 0;
    logic       wr_en = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       stop_entry = 0;
    logic [1:0] oc_in = 0, pwm_in = 0, pwm_sel = 0;
    logic [1:0] gate_out;

    int n_chk = 0, n_err = 0;
    bit done_flag = 0;

    lsgate_ctrl #(.SETTLE_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .stop_entry(stop_entry), .oc_in(oc_in), .pwm_in(pwm_in),
        .pwm_sel(pwm_sel), .gate_out(gate_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        addr = a;
        #0.5;
        v = int'(rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        rd(0, v); chk("R1 gate reg", v, 0);
        rd(1, v); chk("R1 ctrl reg", v, 0);
        chk("R1 gate_out", int'(gate_out), 0);

        // R2: full sweep of the gate register, unrouted; gate stays off while disabled (R5)
        for (int w = 0; w < 256; w++) begin
            wr(0, 8'(w));
            rd(0, v); chk("R2 gate readback", v, w & 3);
            chk("R5 gate off when disabled", int'(gate_out), 0);
        end

        // R3: full sweep of the control register
        for (int w = 0; w < 256; w++) begin
            wr(1, 8'(w));
            rd(1, v); chk("R3 ctrl readback", v, w & 8'h33);
        end

        // R8: unmapped offsets
        wr(1, 8'h00); wr(0, 8'h02);
        for (int a = 2; a < 16; a++) begin
            wr(4'(a), 8'hFF);
            rd(4'(a), v); chk("R8 unmapped read", v, 0);
        end
        rd(0, v); chk("R8 gate reg untouched", v, 2);
        rd(1, v); chk("R8 ctrl reg untouched", v, 0);

        // R6: settling window after enable
        wr(0, 8'h03);
        wr(1, 8'h03);
        for (int k = 0; k <= S + 2; k++) begin
            chk("R6 settle first", int'(gate_out), (k >= S) ? 3 : 0);
            @(negedge clk);
        end
        // R6: restart after drop and re-enable
        wr(1, 8'h00);
        chk("R5 gate off after disable", int'(gate_out), 0);
        wr(1, 8'h03);
        for (int k = 0; k <= S + 2; k++) begin
            chk("R6 settle restart", int'(gate_out), (k >= S) ? 3 : 0);
            @(negedge clk);
        end
        // R5: one channel enabled; no rise on ch0, ch1 disabled
        wr(1, 8'h01);
        chk("R5 single channel", int'(gate_out), 1);
        wr(1, 8'h03);
        repeat (S) @(negedge clk);

        // R4/R5: both routed, all source combinations
        wr(1, 8'h33);
        for (int c = 0; c < 64; c++) begin
            int e;
            @(negedge clk);
            oc_in = 2'(c); pwm_in = 2'(c >> 2); pwm_sel = 2'(c >> 4);
            e = int'((pwm_sel & pwm_in) | (~pwm_sel & oc_in));
            rd(0, v); chk("R4 routed read", v, e);
            chk("R5 routed gate", int'(gate_out), e);
        end

        // R7: STOP entry clears, also over a same-cycle write
        wr(0, 8'h03);
        @(negedge clk);
        stop_entry = 1;
        @(negedge clk);
        stop_entry = 0;
        wr(1, 8'h03);
        rd(0, v); chk("R7 stop clears", v, 0);
        wr(0, 8'h03);
        @(negedge clk);
        addr = 0; wdata = 8'h03; wr_en = 1; stop_entry = 1;
        @(negedge clk);
        wr_en = 0; stop_entry = 0;
        rd(0, v); chk("R7 stop beats write", v, 0);
        chk("R7 gate off after stop", int'(gate_out), 0);
        rd(1, v); chk("R7 ctrl kept", v, 3);

        // R4: partial routing, stored bit survives routing
        wr(0, 8'h02);
        wr(1, 8'h13);
        pwm_sel = 0; oc_in = 2'b01;
        rd(0, v); chk("R4 ch0 routed high", v, 3);
        chk("R5 gate mixed sources", int'(gate_out), 3);
        oc_in = 2'b00;
        rd(0, v); chk("R4 ch0 routed low", v, 2);
        wr(1, 8'h03);
        rd(0, v); chk("R4 stored bit kept", v, 2);
        chk("R5 gate from stored", int'(gate_out), 2);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule